// File: doc/BRIEF.md
# Thread Block Admission Dispatcher

The dispatcher takes thread-block launch requests from a grid queue, one at a time and in order, and places each whole block on one of several multiprocessor slots. A block is placed only where all three of a slot's resources still cover it: the count of resident blocks, the count of resident threads, and the register file entries, which are shared out dynamically among the resident blocks. Each request carries a thread count and a per-thread register count, and the block needs their product in registers.

When a block is placed, the dispatcher reports the chosen slot and the base offset of a contiguous register range reserved for it. It charges the block's resources to that slot. A completion pulse naming a slot and the finished block's thread count returns that block's entry and its threads. Registers come from a per-slot bump pointer, which goes back to zero once the slot holds no blocks. A request that can never be placed is consumed and flagged as rejected. A valid request that fits nowhere at present is held with ready/valid backpressure until a completion frees room, so the grid order is kept.

Top module: `blk_admit`

## Requirements
- R1: A block is placed whole on exactly one slot, and only on a slot where the block count, the thread count and the register pointer all stay within their limits after the block is added.
- R2: A slot never holds more than 8 resident blocks; a request that fits nowhere for this reason stalls.
- R3: A slot never holds more than 768 resident threads (a total of exactly 768 is allowed).
- R4: A placed block needs threads times registers-per-thread entries. Its base is the slot's register pointer, which then advances by that amount and never passes 8192, so the ranges of resident blocks do not overlap.
- R5: A request with 0 threads, with more than 512 threads, or needing more than 8192 registers is accepted at once (ready high), causes a reject pulse on the next cycle, and changes no slot state.
- R6: Slots are searched round-robin, starting with the slot after the one that last received a block; the first slot that fits is taken.
- R7: While a valid request fits no slot, ready stays low, and nothing is placed or rejected.
- R8: A completion pulse on a slot that holds blocks removes one block and the given thread count; when the slot's block count reaches zero, its thread count and register pointer return to zero.
- R9: An accepted, valid request produces a one-cycle assign pulse with slot and base on the cycle after the handshake.
- R10: After reset all slots are empty, no pulses are output, and the first block goes to slot 0 with base 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Launch request present |
| req_ready | output | 1 | Request consumed on this edge (placed or rejected) |
| req_threads | input | 10 | Threads in the block |
| req_regs | input | 6 | Registers per thread |
| done_valid | input | 1 | One block on done_slot has completed |
| done_slot | input | 2 | Slot of the completed block |
| done_threads | input | 10 | Thread count of the completed block |
| assign_valid | output | 1 | Placement pulse |
| assign_slot | output | 2 | Slot chosen for the block |
| assign_base | output | 14 | Base offset of the block's register range |
| reject_valid | output | 1 | Request was invalid and has been dropped |

## Verification
The assertions assume that request fields stay stable while req_valid is high and unaccepted. They also assume that completions only name slots holding blocks and give the thread count of a block that was really placed there. The bench keeps a model of every resident block and completes only blocks from that list, each with its own thread count. It drives every request field at the falling edge and holds it until the handshake. Random request sizes push the slots against all three limits, and directed sequences hit the exact thread limit, the block-count limit, and every reject condition.

// File: rtl/ba_pkg.sv
package ba_pkg;
    typedef enum logic [1:0] {
        EV_IDLE   = 2'd0,
        EV_PLACE  = 2'd1,
        EV_REJECT = 2'd2
    } ev_e;
endpackage

// File: rtl/ba_req_check.sv
module ba_req_check #(
    parameter int REQ_T_W         = 10,
    parameter int RPT_W           = 6,
    parameter int MAX_BLK_THREADS = 512,
    parameter int REG_TOTAL       = 8192,
    parameter int REG_W           = 14
) (
    input  logic [REQ_T_W-1:0] threads,
    input  logic [RPT_W-1:0]   regs_per_thr,
    output logic [REG_W-1:0]   need,
    output logic               bad
);
    localparam int NEED_W = REQ_T_W + RPT_W;

    logic [NEED_W-1:0] prod;

    always_comb begin
        prod = NEED_W'(threads) * NEED_W'(regs_per_thr);
        bad  = (threads == '0)
            || (32'(threads) > 32'(MAX_BLK_THREADS))
            || (32'(prod) > 32'(REG_TOTAL));
        need = REG_W'(prod);
    end
endmodule

// File: rtl/ba_fit.sv
module ba_fit #(
    parameter int BLK_W       = 4,
    parameter int THR_W       = 10,
    parameter int REG_W       = 14,
    parameter int REQ_T_W     = 10,
    parameter int MAX_BLOCKS  = 8,
    parameter int MAX_THREADS = 768,
    parameter int REG_TOTAL   = 8192
) (
    input  logic [BLK_W-1:0]   blocks,
    input  logic [THR_W-1:0]   threads,
    input  logic [REG_W-1:0]   ptr,
    input  logic [REQ_T_W-1:0] req_thr,
    input  logic [REG_W-1:0]   req_need,
    output logic               fit
);
    logic ok_blk, ok_thr, ok_reg;

    always_comb begin
        ok_blk = 32'(blocks) < 32'(MAX_BLOCKS);
        ok_thr = (32'(threads) + 32'(req_thr)) <= 32'(MAX_THREADS);
        ok_reg = (32'(ptr) + 32'(req_need)) <= 32'(REG_TOTAL);
        fit    = ok_blk && ok_thr && ok_reg;
    end
endmodule

// File: rtl/ba_rr_pick.sv
module ba_rr_pick #(
    parameter int N_SLOTS = 4,
    parameter int IDX_W   = 2
) (
    input  logic [N_SLOTS-1:0] fit,
    input  logic [IDX_W-1:0]   last,
    output logic               found,
    output logic [IDX_W-1:0]   idx
);
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int k = 1; k <= N_SLOTS; k++) begin
            int s;
            s = (int'(last) + k) % N_SLOTS;
            if (!found && fit[s]) begin
                found = 1'b1;
                idx   = IDX_W'(s);
            end
        end
    end
endmodule

// File: rtl/blk_admit.sv
module blk_admit #(
    parameter int N_SLOTS         = 4,
    parameter int MAX_BLOCKS      = 8,
    parameter int MAX_THREADS     = 768,
    parameter int REG_TOTAL       = 8192,
    parameter int MAX_BLK_THREADS = 512,
    parameter int REQ_T_W         = 10,
    parameter int RPT_W           = 6,
    localparam int IDX_W          = (N_SLOTS > 1) ? $clog2(N_SLOTS) : 1,
    localparam int REG_W          = $clog2(REG_TOTAL + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_valid,
    output logic               req_ready,
    input  logic [REQ_T_W-1:0] req_threads,
    input  logic [RPT_W-1:0]   req_regs,
    input  logic               done_valid,
    input  logic [IDX_W-1:0]   done_slot,
    input  logic [REQ_T_W-1:0] done_threads,
    output logic               assign_valid,
    output logic [IDX_W-1:0]   assign_slot,
    output logic [REG_W-1:0]   assign_base,
    output logic               reject_valid
);
    import ba_pkg::*;

    localparam int BLK_W = $clog2(MAX_BLOCKS + 1);
    localparam int THR_W = $clog2(MAX_THREADS + 1);

    typedef struct packed {
        logic [BLK_W-1:0] blocks;
        logic [THR_W-1:0] threads;
        logic [REG_W-1:0] ptr;
    } slot_t;

    typedef struct packed {
        slot_t [N_SLOTS-1:0] slots;
        logic [IDX_W-1:0]    last;
        ev_e                 ev;
        logic [IDX_W-1:0]    out_idx;
        logic [REG_W-1:0]    out_base;
    } state_t;

    state_t st_q, st_d;

    logic [REG_W-1:0]   req_need;
    logic               req_bad;
    logic [N_SLOTS-1:0] fit_vec;
    logic               pick_found;
    logic [IDX_W-1:0]   pick_idx;

    ba_req_check #(
        .REQ_T_W(REQ_T_W), .RPT_W(RPT_W), .MAX_BLK_THREADS(MAX_BLK_THREADS),
        .REG_TOTAL(REG_TOTAL), .REG_W(REG_W)
    ) i_req_check (
        .threads(req_threads), .regs_per_thr(req_regs),
        .need(req_need), .bad(req_bad)
    );

    for (genvar g = 0; g < N_SLOTS; g++) begin : g_fit
        ba_fit #(
            .BLK_W(BLK_W), .THR_W(THR_W), .REG_W(REG_W), .REQ_T_W(REQ_T_W),
            .MAX_BLOCKS(MAX_BLOCKS), .MAX_THREADS(MAX_THREADS), .REG_TOTAL(REG_TOTAL)
        ) i_fit (
            .blocks(st_q.slots[g].blocks), .threads(st_q.slots[g].threads),
            .ptr(st_q.slots[g].ptr), .req_thr(req_threads), .req_need(req_need),
            .fit(fit_vec[g])
        );
    end

    ba_rr_pick #(.N_SLOTS(N_SLOTS), .IDX_W(IDX_W)) i_pick (
        .fit(fit_vec), .last(st_q.last), .found(pick_found), .idx(pick_idx)
    );

    assign req_ready = req_bad || pick_found;

    always_comb begin
        logic take;
        st_d    = st_q;
        st_d.ev = EV_IDLE;
        take    = req_valid && req_ready;

        // completion returns one block and its threads
        for (int s = 0; s < N_SLOTS; s++) begin
            if (done_valid && (int'(done_slot) == s) && (st_q.slots[s].blocks != '0)) begin
                st_d.slots[s].blocks = st_q.slots[s].blocks - BLK_W'(1);
                if (32'(done_threads) >= 32'(st_q.slots[s].threads))
                    st_d.slots[s].threads = '0;
                else
                    st_d.slots[s].threads = st_q.slots[s].threads - THR_W'(done_threads);
            end
        end

        if (take && req_bad) begin
            st_d.ev = EV_REJECT;
        end else if (take) begin
            st_d.ev       = EV_PLACE;
            st_d.out_idx  = pick_idx;
            st_d.out_base = st_q.slots[pick_idx].ptr;
            st_d.last     = pick_idx;
            st_d.slots[pick_idx].blocks  = st_d.slots[pick_idx].blocks + BLK_W'(1);
            st_d.slots[pick_idx].threads = st_d.slots[pick_idx].threads + THR_W'(req_threads);
            st_d.slots[pick_idx].ptr     = st_q.slots[pick_idx].ptr + req_need;
        end

        // an emptied slot gives back its whole register range
        for (int s = 0; s < N_SLOTS; s++) begin
            if (st_d.slots[s].blocks == '0) begin
                st_d.slots[s].threads = '0;
                st_d.slots[s].ptr     = '0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q          <= '0;
            st_q.last     <= IDX_W'(N_SLOTS - 1);
            st_q.ev       <= EV_IDLE;
        end else begin
            st_q <= st_d;
        end
    end

    assign assign_valid = (st_q.ev == EV_PLACE);
    assign reject_valid = (st_q.ev == EV_REJECT);
    assign assign_slot  = st_q.out_idx;
    assign assign_base  = st_q.out_base;
endmodule

// File: rtl/ba_checker.sv
module ba_checker #(
    parameter int REG_TOTAL = 8192,
    parameter int REG_W     = 14
) (
    input logic             clk,
    input logic             rst_n,
    input logic             req_valid,
    input logic             req_ready,
    input logic             req_bad,
    input logic             assign_valid,
    input logic             reject_valid,
    input logic [REG_W-1:0] assign_base
);
    a_r5_bad_taken: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_bad |-> req_ready);

    a_r5_reject_next: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_ready && req_bad |=> reject_valid && !assign_valid);

    a_r9_place_next: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_ready && !req_bad |=> assign_valid && !reject_valid);

    a_r7_quiet_on_stall: assert property (@(posedge clk) disable iff (!rst_n)
        !(req_valid && req_ready) |=> !assign_valid && !reject_valid);

    a_r4_base_bound: assert property (@(posedge clk) disable iff (!rst_n)
        assign_valid |-> 32'(assign_base) <= 32'(REG_TOTAL));

    a_r9_one_event: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({assign_valid, reject_valid}));
endmodule

bind blk_admit ba_checker #(.REG_TOTAL(REG_TOTAL), .REG_W(REG_W)) i_ba_checker (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_bad(req_bad), .assign_valid(assign_valid), .reject_valid(reject_valid),
    .assign_base(assign_base)
);

// File: tb/test_blk_admit.sv
module test_blk_admit;
    localparam int N  = 4;
    localparam int MB = 8;
    localparam int MT = 768;
    localparam int RT = 8192;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       req_valid = 1'b0;
    logic       req_ready;
    logic [9:0] req_threads = '0;
    logic [5:0] req_regs = '0;
    logic       done_valid = 1'b0;
    logic [1:0] done_slot = '0;
    logic [9:0] done_threads = '0;
    logic       assign_valid;
    logic [1:0] assign_slot;
    logic [13:0] assign_base;
    logic       reject_valid;

    int checks = 0;
    int fails  = 0;
    bit ended  = 0;

    int m_blocks[N];
    int m_thr[N];
    int m_ptr[N];
    int m_res[N][MB];
    int m_last;

    always #5 clk = ~clk;

    blk_admit i_blk_admit (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_threads(req_threads), .req_regs(req_regs), .done_valid(done_valid),
        .done_slot(done_slot), .done_threads(done_threads),
        .assign_valid(assign_valid), .assign_slot(assign_slot),
        .assign_base(assign_base), .reject_valid(reject_valid)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic bit model_fits(int s, int t, int need);
        return (m_blocks[s] < MB) && (m_thr[s] + t <= MT) && (m_ptr[s] + need <= RT);
    endfunction

    function automatic int model_pick(int t, int need);
        for (int k = 1; k <= N; k++) begin
            int s;
            s = (m_last + k) % N;
            if (model_fits(s, t, need)) return s;
        end
        return -1;
    endfunction

    function automatic int total_blocks();
        int n = 0;
        for (int s = 0; s < N; s++) n += m_blocks[s];
        return n;
    endfunction

    task automatic model_remove(int s, int j);
        m_thr[s] -= m_res[s][j];
        for (int i = j; i < MB - 1; i++) m_res[s][i] = m_res[s][i+1];
        m_blocks[s]--;
        if (m_blocks[s] == 0) begin
            m_thr[s] = 0;
            m_ptr[s] = 0;
        end
    endtask

    // completion pulse for block j of slot s; caller is at a falling edge
    task automatic do_done(int s, int j);
        done_valid   = 1'b1;
        done_slot    = 2'(s);
        done_threads = 10'(m_res[s][j]);
        @(negedge clk);
        done_valid = 1'b0;
        model_remove(s, j);
        #1;
    endtask

    task automatic do_req(int t, int r, string tag);
        int need;
        bit bad;
        need = t * r;
        bad  = (t == 0) || (t > 512) || (need > RT);
        req_valid   = 1'b1;
        req_threads = 10'(t);
        req_regs    = 6'(r);
        #1;
        if (bad) begin
            chk(req_ready == 1'b1, {tag, " R5 bad request taken"}, int'(req_ready), 1);
            @(negedge clk);
            req_valid = 1'b0;
            chk(reject_valid == 1'b1 && assign_valid == 1'b0, {tag, " R5 reject pulse"},
                int'({reject_valid, assign_valid}), 2);
            #1;
            return;
        end
        forever begin
            int p;
            p = model_pick(t, need);
            if (p < 0) begin
                chk(req_ready == 1'b0, {tag, " R7 stall while nothing fits"}, int'(req_ready), 0);
                for (int k = 1; k <= N; k++) begin
                    int s;
                    s = (m_last + k) % N;
                    if (m_blocks[s] > 0) begin
                        do_done(s, 0);
                        break;
                    end
                end
                chk(assign_valid == 1'b0 && reject_valid == 1'b0, {tag, " R7 nothing issued"},
                    int'({assign_valid, reject_valid}), 0);
            end else begin
                chk(req_ready == 1'b1, {tag, " R1 ready when a slot fits"}, int'(req_ready), 1);
                @(negedge clk);
                req_valid = 1'b0;
                chk(assign_valid == 1'b1, {tag, " R9 assign pulse"}, int'(assign_valid), 1);
                chk(int'(assign_slot) == p, {tag, " R6 round-robin slot"}, int'(assign_slot), p);
                chk(int'(assign_base) == m_ptr[p], {tag, " R4/R8 register base"},
                    int'(assign_base), m_ptr[p]);
                m_res[p][m_blocks[p]] = t;
                m_blocks[p]++;
                m_thr[p] += t;
                m_ptr[p] += need;
                m_last = p;
                #1;
                return;
            end
        end
    endtask

    task automatic drain();
        while (total_blocks() > 0) begin
            for (int s = 0; s < N; s++)
                if (m_blocks[s] > 0) do_done(s, 0);
        end
    endtask

    initial begin
        #1_000_000;
        if (!ended) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        for (int s = 0; s < N; s++) begin
            m_blocks[s] = 0; m_thr[s] = 0; m_ptr[s] = 0;
        end
        m_last = N - 1;
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        #1;
        chk(assign_valid == 1'b0 && reject_valid == 1'b0, "R10 no pulses after reset",
            int'({assign_valid, reject_valid}), 0);

        // R10: first block lands on slot 0 at base 0; R3 thread limit
        do_req(512, 1, "R10");
        do_req(512, 1, "R3");
        do_req(512, 1, "R3");
        do_req(512, 1, "R3");
        do_req(256, 1, "R3 exact 768");
        do_req(257, 1, "R3 over 768");

        // R5 reject cases, state must stay untouched (next placement checks it)
        do_req(0, 4, "R5 zero");
        do_req(513, 1, "R5 too many threads");
        do_req(512, 17, "R5 register overflow");
        drain();

        // R2 block-count limit: 32 fit, the 33rd stalls
        for (int i = 0; i < N * MB; i++) do_req(1, 0, "R2");
        do_req(1, 0, "R2 ninth block");
        drain();

        // R4 full register file on one slot, then R8 reset of the pointer
        do_req(512, 16, "R4 full file");
        do_req(16, 4, "R4");
        drain();
        do_req(8, 8, "R8 pointer back to zero");
        drain();

        // random mix
        for (int i = 0; i < 400; i++) begin
            int sel;
            sel = int'($urandom_range(0, 9));
            if (sel < 3 && total_blocks() > 0) begin
                int s;
                s = int'($urandom_range(0, N - 1));
                while (m_blocks[s] == 0) s = (s + 1) % N;
                do_done(s, int'($urandom_range(0, m_blocks[s] - 1)));
            end else if (sel == 3) begin
                do_req(int'($urandom_range(0, 600)), int'($urandom_range(0, 40)), "R1 random");
            end else begin
                do_req(int'($urandom_range(1, 400)), int'($urandom_range(0, 24)), "R1 random");
            end
        end
        drain();

        ended = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule